// File: doc/BRIEF.md
# Byte-Wide EPROM Emulator

This block stands in for a byte-wide, UV-erasable programmable read-only memory on a synchronous system bus. A bus master presents an address with an active-low chip select and an active-low output enable, and receives a byte one clock later. Parallel lines replace the tri-state data pins: data in, data out and a drive-enable. An FPGA pad or a bus multiplexer can rebuild the shared bus from these three lines.

The high programming voltage and the raised level on address line 9 are not modelled as voltages. Two flag inputs carry them instead. With the programming flag set and the chip selected, the byte on the data inputs is merged into the addressed cell. Programming can only clear bits. Setting the high-level flag on line 9 turns reads into an identifier readout. Address bit 0 then selects the maker code or the part code, and both codes carry odd parity.

A one-cycle erase request, and also reset, starts a sweep that writes all-ones through every location. While the sweep runs the emulator neither drives the bus nor programs. The array is plain single-port-write, registered-read storage, so block RAM can hold it.

Top module: `eprom_emu`

## Requirements
- R1: Outputs are registered with one clock of latency. `dq_oe` is high in a cycle only if, at the preceding clock edge, `ce_n` and `oe_n` were both low, `vpp_on` was low and `erase_busy` was low. With those conditions met, `dq_oe` is high.
- R2: With `ce_n` high (standby), `dq_oe` is low on the next cycle whatever `oe_n`, `a9_hv` and `vpp_on` are.
- R3: With `a9_hv` high, the chip selected and output enabled, and every address bit other than bit 0 and bit `ID_BIT` (default 9) zero, the next cycle drives `MFR_ID` when address bit 0 is 0 and `DEV_ID` when it is 1.
- R4: In identifier readout, if any address bit other than bit 0 and bit `ID_BIT` is one, the driven byte is all ones.
- R5: Each identifier byte has an odd number of ones, and its top bit is the parity over the lower bits. An identifier parameter with even parity stops elaboration.
- R6: Reset and an `erase_req` pulse each hold `erase_busy` high for exactly 2^`ADDR_W` cycles. During that time outputs are not driven and program cycles have no effect. Afterwards every location reads all ones.
- R7: A program cycle (`vpp_on` high, `ce_n` low, not erasing) stores the bitwise AND of `dq_in` and the current byte, so programming never turns a 0 back into a 1.
- R8: With `ce_n` high, a cycle with `vpp_on` high leaves the array unchanged.
- R9: Program cycles do not drive outputs. Program cycles and reads on consecutive clocks to the same address see each earlier write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts an erase sweep |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data to program |
| dq_out | output | DATA_W | Read or identifier data; zero when not driven |
| dq_oe | output | 1 | Drive enable for dq_out |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| vpp_on | input | 1 | Programming-voltage-present flag |
| a9_hv | input | 1 | High level present on address line 9 |
| erase_req | input | 1 | One-cycle request to erase the whole array |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The assertions assume that every control input is a clean, clock-synchronous level and that `erase_req` is a single-cycle pulse. They also assume that during identifier readout the programming flag stays low. Otherwise the priority of programming over readout would keep the parity property from applying. The bench changes inputs only on falling edges, one table row per clock. It holds `erase_req` for one cycle and raises `a9_hv` only in rows that have `vpp_on` low. Each row that expects an identifier byte also checks its parity at the outputs.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;

  // Bus cycle class decoded from the control inputs, highest priority first.
  typedef enum logic [2:0] {
    MODE_SWEEP   = 3'd0,  // erase sweep owns the array
    MODE_STANDBY = 3'd1,  // chip not selected
    MODE_PROG    = 3'd2,  // program cycle
    MODE_OFF     = 3'd3,  // selected, outputs disabled
    MODE_IDENT   = 3'd4,  // identifier readout
    MODE_READ    = 3'd5   // array read
  } bus_mode_e;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_emu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int ID_BIT = 9,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h1C
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on,
  input  logic              a9_hv,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output bus_mode_e         mode,
  output logic [DATA_W-1:0] id_byte
);

  // Address bits allowed to be nonzero during identifier readout.
  localparam logic [ADDR_W-1:0] ID_FREE_MASK =
    (ADDR_W'(1) << ID_BIT) | ADDR_W'(1);

  logic stray_bits;

  always_comb begin
    stray_bits = |(addr & ~ID_FREE_MASK);
    if (stray_bits)      id_byte = '1;
    else if (addr[0])    id_byte = DEV_ID;
    else                 id_byte = MFR_ID;
  end

  always_comb begin
    if (busy)         mode = MODE_SWEEP;
    else if (ce_n)    mode = MODE_STANDBY;
    else if (vpp_on)  mode = MODE_PROG;
    else if (oe_n)    mode = MODE_OFF;
    else if (a9_hv)   mode = MODE_IDENT;
    else              mode = MODE_READ;
  end

endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_req,
  output logic              busy,
  output logic [ADDR_W-1:0] sweep_addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b1;
      sweep_addr <= '0;
    end else if (busy) begin
      sweep_addr <= sweep_addr + ADDR_W'(1);
      if (sweep_addr == LAST_ADDR) busy <= 1'b0;
    end else if (erase_req) begin
      busy       <= 1'b1;
      sweep_addr <= '0;
    end
  end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single-clock RAM; no reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end

endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
  import eprom_emu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int ID_BIT = 9,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on,
  input  logic              a9_hv,
  input  logic              erase_req,
  output logic              erase_busy
);

  // Elaboration-time guard on identifier parity (R5).
  if (^MFR_ID != 1'b1) begin : g_bad_mfr_parity
    $error("MFR_ID must have odd parity");
  end
  if (^DEV_ID != 1'b1) begin : g_bad_dev_parity
    $error("DEV_ID must have odd parity");
  end
  if (ID_BIT >= ADDR_W || ID_BIT < 1) begin : g_bad_id_bit
    $error("ID_BIT must be an address bit above bit 0");
  end

  bus_mode_e         mode;
  logic [DATA_W-1:0] id_byte;
  logic              busy;
  logic [ADDR_W-1:0] sweep_addr;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] cur_byte;

  // Cycle-stage registers.
  logic [ADDR_W-1:0] r_addr;
  logic              oe_r;
  logic              sel_id_r;
  logic [DATA_W-1:0] id_r;
  logic              p_valid;
  logic [DATA_W-1:0] p_din;

  // Last-write bypass register.
  logic              lw_valid;
  logic [ADDR_W-1:0] lw_addr;
  logic [DATA_W-1:0] lw_data;

  eprom_mode_dec #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_BIT (ID_BIT),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
  ) u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_on  (vpp_on),
    .a9_hv   (a9_hv),
    .busy    (busy),
    .addr    (addr),
    .mode    (mode),
    .id_byte (id_byte)
  );

  eprom_erase_seq #(
    .ADDR_W (ADDR_W)
  ) u_erase (
    .clk        (clk),
    .rst        (rst),
    .erase_req  (erase_req),
    .busy       (busy),
    .sweep_addr (sweep_addr)
  );

  eprom_cell_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (addr),
    .q     (ram_q)
  );

  // The RAM read missed only a write landing on the same edge; bypass it.
  always_comb begin
    if (lw_valid && (lw_addr == r_addr)) cur_byte = lw_data;
    else                                 cur_byte = ram_q;
  end

  // Sweep has priority; a program pending at sweep start is dropped.
  always_comb begin
    if (busy) begin
      wr_en   = 1'b1;
      wr_addr = sweep_addr;
      wr_data = '1;
    end else begin
      wr_en   = p_valid;
      wr_addr = r_addr;
      wr_data = cur_byte & p_din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_addr   <= '0;
      oe_r     <= 1'b0;
      sel_id_r <= 1'b0;
      id_r     <= '0;
      p_valid  <= 1'b0;
      p_din    <= '0;
      lw_valid <= 1'b0;
      lw_addr  <= '0;
      lw_data  <= '0;
    end else begin
      r_addr   <= addr;
      oe_r     <= (mode == MODE_READ) || (mode == MODE_IDENT);
      sel_id_r <= (mode == MODE_IDENT);
      id_r     <= id_byte;
      p_valid  <= (mode == MODE_PROG);
      p_din    <= dq_in;
      lw_valid <= wr_en;
      if (wr_en) begin
        lw_addr <= wr_addr;
        lw_data <= wr_data;
      end
    end
  end

  always_comb begin
    if (!oe_r)        dq_out = '0;
    else if (sel_id_r) dq_out = id_r;
    else              dq_out = cur_byte;
  end

  assign dq_oe      = oe_r;
  assign erase_busy = busy;

endmodule

// File: rtl/eprom_emu_chk.sv
module eprom_emu_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int ID_BIT = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_on,
  input logic              a9_hv,
  input logic              erase_req,
  input logic              erase_busy,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out
);

  localparam logic [ADDR_W-1:0] FREE_MASK = (ADDR_W'(1) << ID_BIT) | ADDR_W'(1);

  logic rd_sel;
  logic id_clean;
  logic id_stray;

  assign rd_sel   = !ce_n && !oe_n && !vpp_on && !erase_busy;
  assign id_clean = rd_sel && a9_hv && ((addr & ~FREE_MASK) == '0);
  assign id_stray = rd_sel && a9_hv && ((addr & ~FREE_MASK) != '0);

  AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |=> !dq_oe);                                           // R1
  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    rd_sel |=> dq_oe);                                                    // R1
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dq_oe);                                                     // R2
  AST_ID_STRAY_ONES: assert property (@(posedge clk) disable iff (rst)
    id_stray |=> (dq_out == '1));                                         // R4
  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
    id_clean |=> (dq_oe && (^dq_out == 1'b1)));                           // R5
  AST_ERASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    erase_busy |=> !dq_oe);                                               // R6
  AST_ERASE_START: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !erase_busy) |=> erase_busy);                           // R6
  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && vpp_on) |=> !dq_oe);                                        // R9

endmodule

bind eprom_emu eprom_emu_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ID_BIT (ID_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .vpp_on     (vpp_on),
  .a9_hv      (a9_hv),
  .erase_req  (erase_req),
  .erase_busy (erase_busy),
  .dq_oe      (dq_oe),
  .dq_out     (dq_out)
);

// File: tb/tb_eprom_emu.sv
module tb_eprom_emu;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam logic [7:0] T_MFR = 8'h01;
  localparam logic [7:0] T_DEV = 8'h1C;
  localparam int SWEEP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic          ce_n, oe_n, vpp_on, a9_hv, erase_req;
  logic          erase_busy;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  eprom_emu #(
    .ADDR_W (AW), .DATA_W (DW), .ID_BIT (9), .MFR_ID (T_MFR), .DEV_ID (T_DEV)
  ) dut (
    .clk (clk), .rst (rst), .addr (addr), .dq_in (dq_in), .dq_out (dq_out),
    .dq_oe (dq_oe), .ce_n (ce_n), .oe_n (oe_n), .vpp_on (vpp_on),
    .a9_hv (a9_hv), .erase_req (erase_req), .erase_busy (erase_busy)
  );

  typedef struct packed {
    logic          ce_n;
    logic          oe_n;
    logic          vpp;
    logic          hv;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic          exp_oe;
    logic [7:0]    exp_dq;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,11'h000,8'h00,1'b1,8'hFF,4'd6}, // R6 erased read
    '{1'b0,1'b1,1'b1,1'b0,11'h005,8'hA5,1'b0,8'h00,4'd9}, // R9 program
    '{1'b0,1'b0,1'b0,1'b0,11'h005,8'h00,1'b1,8'hA5,4'd7}, // R7
    '{1'b0,1'b1,1'b1,1'b0,11'h005,8'h3C,1'b0,8'h00,4'd9}, // R9
    '{1'b0,1'b0,1'b0,1'b0,11'h005,8'h00,1'b1,8'h24,4'd7}, // R7 AND merge
    '{1'b0,1'b1,1'b1,1'b0,11'h005,8'hFF,1'b0,8'h00,4'd9}, // R9
    '{1'b0,1'b0,1'b0,1'b0,11'h005,8'h00,1'b1,8'h24,4'd7}, // R7 no 0->1
    '{1'b1,1'b0,1'b1,1'b0,11'h006,8'h00,1'b0,8'h00,4'd8}, // R8 deselected
    '{1'b0,1'b0,1'b0,1'b0,11'h006,8'h00,1'b1,8'hFF,4'd8}, // R8
    '{1'b1,1'b0,1'b0,1'b0,11'h005,8'h00,1'b0,8'h00,4'd2}, // R2 standby
    '{1'b0,1'b1,1'b0,1'b0,11'h005,8'h00,1'b0,8'h00,4'd1}, // R1 oe high
    '{1'b0,1'b0,1'b0,1'b1,11'h200,8'h00,1'b1,8'h01,4'd3}, // R3 maker
    '{1'b0,1'b0,1'b0,1'b1,11'h201,8'h00,1'b1,8'h1C,4'd3}, // R3 part
    '{1'b0,1'b0,1'b0,1'b1,11'h203,8'h00,1'b1,8'hFF,4'd4}, // R4 bit 1 set
    '{1'b0,1'b0,1'b0,1'b1,11'h601,8'h00,1'b1,8'hFF,4'd4}, // R4 bit 10 set
    '{1'b1,1'b0,1'b0,1'b1,11'h200,8'h00,1'b0,8'h00,4'd2}, // R2 id standby
    '{1'b0,1'b1,1'b1,1'b0,11'h7FF,8'h0F,1'b0,8'h00,4'd9}, // R9 back-to-back
    '{1'b0,1'b1,1'b1,1'b0,11'h7FF,8'hF0,1'b0,8'h00,4'd9}, // R9
    '{1'b0,1'b0,1'b0,1'b0,11'h7FF,8'h00,1'b1,8'h00,4'd9}  // R9 both merged
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; vpp_on = 1'b0; a9_hv = 1'b0;
    erase_req = 1'b0; addr = '0; dq_in = '0;
  endtask

  task automatic read_at(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    ce_n = 1'b0; oe_n = 1'b0; vpp_on = 1'b0; a9_hv = 1'b0; addr = a;
    @(negedge clk);
    chk(req, {dq_oe, dq_out}, {1'b1, exp});
    idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 reset", {dq_oe, erase_busy, 7'd0}, {1'b0, 1'b1, 7'd0});
    rst = 1'b0;
    // R6: sweep length after reset, outputs quiet even with a read driven
    begin
      int n = 0;
      bit loud = 1'b0;
      ce_n = 1'b0; oe_n = 1'b0;
      while (erase_busy && n < SWEEP + 10) begin
        n++;
        @(negedge clk);
        if (erase_busy && dq_oe) loud = 1'b1;
      end
      idle();
      chk("R6 reset sweep length", 9'(n), 9'(SWEEP & 9'h1FF));
      chk("R6 reset sweep quiet", {8'd0, loud}, 9'd0);
      chk("R6 reset sweep cycles", 9'(n >> 9), 9'(SWEEP >> 9));
    end

    // Table walk: one row per clock.
    for (int i = 0; i < NV; i++) begin
      ce_n = VEC[i].ce_n; oe_n = VEC[i].oe_n; vpp_on = VEC[i].vpp;
      a9_hv = VEC[i].hv; addr = VEC[i].addr; dq_in = VEC[i].din;
      @(negedge clk);
      if (VEC[i].exp_oe)
        chk($sformatf("R%0d row %0d", VEC[i].req, i), {dq_oe, dq_out}, {1'b1, VEC[i].exp_dq});
      else
        chk($sformatf("R%0d row %0d", VEC[i].req, i), {8'd0, dq_oe}, 9'd0);
      // R5: any identifier byte read back has odd parity
      if (VEC[i].req == 4'd3)
        chk("R5 parity", {8'd0, ^dq_out}, 9'd1);
    end
    idle();
    @(negedge clk);

    // R6: erase pulse, programs during the sweep are ignored
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    chk("R6 busy after request", {8'd0, erase_busy}, 9'd1);
    begin
      int n = 0;
      bit loud = 1'b0;
      ce_n = 1'b0; vpp_on = 1'b1; addr = 11'h010; dq_in = 8'h00;
      while (erase_busy && n < SWEEP + 10) begin
        n++;
        @(negedge clk);
        if (erase_busy && dq_oe) loud = 1'b1;
      end
      idle();
      chk("R6 erase sweep length", 9'(n), 9'(SWEEP & 9'h1FF));
      chk("R6 erase sweep cycles", 9'(n >> 9), 9'(SWEEP >> 9));
      chk("R6 erase quiet", {8'd0, loud}, 9'd0);
    end
    read_at(11'h005, 8'hFF, "R6 erased 005");
    read_at(11'h7FF, 8'hFF, "R6 erased 7FF");
    read_at(11'h010, 8'hFF, "R6 program during sweep ignored");

    // R7: program then read directly back on next clock
    ce_n = 1'b0; vpp_on = 1'b1; addr = 11'h123; dq_in = 8'h5A;
    @(negedge clk);
    read_at(11'h123, 8'h5A, "R7 program readback");

    // R8: deselected program with zeros leaves the byte intact
    ce_n = 1'b1; vpp_on = 1'b1; addr = 11'h123; dq_in = 8'h00;
    @(negedge clk);
    read_at(11'h123, 8'h5A, "R8 deselected program");

    // R1: output enable alone without chip enable gives no drive
    ce_n = 1'b1; oe_n = 1'b0; addr = 11'h123;
    @(negedge clk);
    chk("R1 no drive", {8'd0, dq_oe}, 9'd0);
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule